// File: doc/BRIEF.md
# Stalling Memory-Mapped Bridge to a Slow Backplane

This block is a memory-mapped slave that gives a fast processor plain read and write access to slow peripheral boards on a backplane. Existing driver code keeps issuing ordinary loads and stores. The bridge holds the processor on a waitrequest line until the off-board transfer is finished. The processor side has an active-low chip select, read and write strobes, an address and a data word. The bridge sends one request to a slow bus engine for each access. It keeps waitrequest high until the engine reports completion with a strobe one clock wide. For a read, it returns the captured word in the same cycle that waitrequest drops, with no separate read-valid line.

The slow bus engine is modelled inside the block. A prescaler divides the processor clock into slow ticks. A per-region table gives the number of slow ticks each access takes, because boards in different address regions respond at different speeds. A small word store stands in for the remote boards' registers.

The control is a three-state machine. `ST_IDLE` waits for a select. The transition *launch* (select low with read or write) raises waitrequest combinationally, pulses the engine request and moves to `ST_BUSY`. `ST_BUSY` holds waitrequest. The transition *complete* (engine strobe) captures read data and moves to `ST_DONE`. `ST_DONE` lasts one cycle with waitrequest low and the select ignored. The transition *rearm* returns to `ST_IDLE`. Reset forces `ST_IDLE` from any state.

Top module: `slowbus_bridge`

## Requirements
- R1: After a synchronous active-high reset, waitreq is low, rdata is zero and every store word is zero.
- R2: In `ST_IDLE`, waitreq goes high in the same cycle that sel_n is low with rd or wr high.
- R3: Each access sends exactly one engine request. No further request is issued while waitreq is held, so the wait is never restarted.
- R4: The region is addr[ADDR_W-1 -: REGION_BITS]. Region r waits TICK_BASE + r*TICK_STEP slow ticks, and each slow tick is SLOW_DIV clocks counted from the request. waitreq is therefore high for exactly ticks*SLOW_DIV+1 consecutive cycles.
- R5: The engine's completion strobe lasts one cycle, and waitreq is low in the cycle after it.
- R6: For a read, rdata holds the addressed word in the first cycle with waitreq low. It keeps that value until the next read completes.
- R7: A write stores wdata at location addr[LOC_W-1:0] at completion. A later read of that location in any region returns it.
- R8: In the one cycle after completion, a select that is still held does not start an access: waitreq is low in that cycle. A select still held one cycle later starts a new access.
- R9: While sel_n is high, rd and wr are ignored: waitreq stays low and nothing is stored.
- R10: An access with both rd and wr high is a read. wdata is not stored.
- R11: A reset asserted during an access abandons it. waitreq is low right after, and the next access has its normal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address; top bits pick the region, low bits the location |
| wdata | input | DATA_W | Write data word |
| rdata | output | DATA_W | Captured read data |
| waitreq | output | 1 | Stall to the processor |

## Verification
The bench builds the bridge with SLOW_DIV of 4 instead of the default 62, and with an 8-bit address whose top two bits select among four regions of 1, 3, 5 and 7 ticks. Every region's exact stall length (5, 13, 21 and 29 cycles) can then be measured cycle by cycle within a short run. With a three-bit location field, the same word can be written through one region and read back through another. The small divider also makes it cheap to cover a held select across completion and a reset partway through the longest region.

// File: rtl/slowbus_pkg.sv
package slowbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } bridge_state_t;

    // Slow-tick count for one address region.
    function automatic int unsigned region_ticks(
        input int unsigned base,
        input int unsigned step,
        input int unsigned region
    );
        return base + region * step;
    endfunction

endpackage

// File: rtl/slowbus_region_map.sv
module slowbus_region_map
    import slowbus_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int REGION_BITS = 2,
    parameter int TICK_BASE   = 1,
    parameter int TICK_STEP   = 2,
    parameter int CNT_W       = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  ticks
);
    localparam int REGIONS = 1 << REGION_BITS;

    logic [CNT_W-1:0] tick_tbl [REGIONS];

    for (genvar r = 0; r < REGIONS; r++) begin : g_region
        assign tick_tbl[r] = CNT_W'(region_ticks(TICK_BASE, TICK_STEP, r));
    end

    assign ticks = tick_tbl[addr[ADDR_W-1 -: REGION_BITS]];

endmodule

// File: rtl/slowbus_engine.sv
module slowbus_engine #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int LOC_W       = 3,
    parameter int REGION_BITS = 2,
    parameter int TICK_BASE   = 1,
    parameter int TICK_STEP   = 2,
    parameter int SLOW_DIV    = 62,
    parameter int CNT_W       = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              done,
    output logic [DATA_W-1:0] word_out
);
    localparam int DEPTH = 1 << LOC_W;
    localparam int PRE_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOW_DIV - 1);

    logic [CNT_W-1:0]  start_ticks;
    logic              busy_q;
    logic [PRE_W-1:0]  pre_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [LOC_W-1:0]  loc_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] store [DEPTH];
    logic              tick;

    slowbus_region_map #(
        .ADDR_W     (ADDR_W),
        .REGION_BITS(REGION_BITS),
        .TICK_BASE  (TICK_BASE),
        .TICK_STEP  (TICK_STEP),
        .CNT_W      (CNT_W)
    ) u_map (
        .addr (req_addr),
        .ticks(start_ticks)
    );

    assign tick     = busy_q && (pre_q == PRE_LAST);
    assign done     = tick && (cnt_q == CNT_W'(1));
    assign word_out = store[loc_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            pre_q   <= '0;
            cnt_q   <= '0;
            loc_q   <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                store[i] <= '0;
            end
        end else if (req) begin
            busy_q  <= 1'b1;
            pre_q   <= '0;
            cnt_q   <= start_ticks;
            loc_q   <= req_addr[LOC_W-1:0];
            write_q <= req_write;
            wdata_q <= req_wdata;
        end else if (busy_q) begin
            if (tick) begin
                pre_q <= '0;
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    if (write_q) begin
                        store[loc_q] <= wdata_q;
                    end
                end
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    // R5: completion strobe is exactly one cycle wide
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: a request never lands on a transfer already in flight
    a_r3_req_when_idle: assert property (@(posedge clk) disable iff (rst)
        req |-> !busy_q);

endmodule

// File: rtl/slowbus_bridge.sv
module slowbus_bridge
    import slowbus_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int LOC_W       = 3,
    parameter int REGION_BITS = 2,
    parameter int TICK_BASE   = 1,
    parameter int TICK_STEP   = 2,
    parameter int SLOW_DIV    = 62
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              waitreq
);
    localparam int MAX_TICKS = TICK_BASE + ((1 << REGION_BITS) - 1) * TICK_STEP;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    bridge_state_t     state_q, state_d;
    logic              access;
    logic              req;
    logic              eng_done;
    logic [DATA_W-1:0] eng_word;
    logic              is_read_q;
    logic [DATA_W-1:0] rdata_q;

    assign access = !sel_n && (rd || wr);

    slowbus_engine #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LOC_W      (LOC_W),
        .REGION_BITS(REGION_BITS),
        .TICK_BASE  (TICK_BASE),
        .TICK_STEP  (TICK_STEP),
        .SLOW_DIV   (SLOW_DIV),
        .CNT_W      (CNT_W)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .req_write(wr && !rd),
        .req_addr (addr),
        .req_wdata(wdata),
        .done     (eng_done),
        .word_out (eng_word)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        req     = 1'b0;
        waitreq = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (access) begin
                    req     = 1'b1;
                    waitreq = 1'b1;
                    state_d = ST_BUSY;
                end
            end
            ST_BUSY: begin
                waitreq = 1'b1;
                if (eng_done) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Read capture
    always_ff @(posedge clk) begin
        if (rst) begin
            is_read_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            if (req) begin
                is_read_q <= rd;
            end
            if (eng_done && is_read_q) begin
                rdata_q <= eng_word;
            end
        end
    end

    assign rdata = rdata_q;

    // R3: stall is held while the engine has not finished
    a_r3_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUSY && !eng_done) |=> waitreq);

    // R5: stall drops in the cycle after completion
    a_r5_release_after_done: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> !waitreq);

    // R6: read data only changes when a completion preceded it
    a_r6_rdata_held: assert property (@(posedge clk) disable iff (rst)
        !eng_done |=> $stable(rdata));

    // R3: completion only arrives while the bridge is waiting
    a_r3_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        eng_done |-> (state_q == ST_BUSY));

endmodule

// File: tb/tb_slowbus_bridge.sv
module tb_slowbus_bridge;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int LOC_W  = 3;
    localparam int DIV    = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sel_n = 1'b1;
    logic              rd = 1'b0;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              waitreq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    slowbus_bridge #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LOC_W      (LOC_W),
        .REGION_BITS(2),
        .TICK_BASE  (1),
        .TICK_STEP  (2),
        .SLOW_DIV   (DIV)
    ) dut (
        .clk    (clk),
        .rst    (rst),
        .sel_n  (sel_n),
        .rd     (rd),
        .wr     (wr),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .waitreq(waitreq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(input int region, input int loc);
        return {2'(region), 3'b000, 3'(loc)};
    endfunction

    function automatic int stall_len(input int region);
        return (1 + 2 * region) * DIV + 1;
    endfunction

    // Drive one access, count stall cycles; ends mid-cycle of the first low-waitreq cycle.
    task automatic run_access(input string req, input logic a_rd, input logic a_wr,
                              input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                              output int len);
        @(negedge clk);
        sel_n = 1'b0; rd = a_rd; wr = a_wr; addr = a; wdata = d;
        #1;
        check({req, " stall same cycle (R2)"}, 32'(waitreq), 32'd1);
        len = 0;
        while (waitreq === 1'b1 && len < 200) begin
            len++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic release_bus();
        sel_n = 1'b1; rd = 1'b0; wr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R1 waitreq after reset", 32'(waitreq), 32'd0);
        check("R1 rdata after reset", 32'(rdata), 32'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_regions();
        int len;
        for (int r = 0; r < 4; r++) begin
            run_access("R4", 1'b0, 1'b1, mk_addr(r, r), 16'hA000 + 16'(r), len);
            check($sformatf("R4 write stall region %0d", r), 32'(len), 32'(stall_len(r)));
            release_bus();
        end
        for (int r = 0; r < 4; r++) begin
            run_access("R6", 1'b1, 1'b0, mk_addr(r, r), '0, len);
            check($sformatf("R4 read stall region %0d", r), 32'(len), 32'(stall_len(r)));
            check($sformatf("R6 read data region %0d", r), 32'(rdata), 32'(16'hA000 + 16'(r)));
            release_bus();
        end
        @(negedge clk);
        #1;
        check("R6 rdata held", 32'(rdata), 32'h0000A003);
    endtask

    task automatic t_cross_region();
        int len;
        run_access("R7", 1'b0, 1'b1, mk_addr(3, 5), 16'h5A5A, len);
        release_bus();
        run_access("R7", 1'b1, 1'b0, mk_addr(0, 5), '0, len);
        check("R7 read back via other region", 32'(rdata), 32'h5A5A);
        check("R4 region 0 stall", 32'(len), 32'(stall_len(0)));
        release_bus();
    endtask

    task automatic t_deselected();
        int len;
        @(negedge clk);
        sel_n = 1'b1; rd = 1'b1; wr = 1'b1; addr = mk_addr(0, 6); wdata = 16'hDEAD;
        for (int i = 0; i < 4; i++) begin
            #1;
            check("R9 no stall without select", 32'(waitreq), 32'd0);
            @(negedge clk);
        end
        release_bus();
        run_access("R9", 1'b1, 1'b0, mk_addr(0, 6), '0, len);
        check("R9 nothing stored", 32'(rdata), 32'd0);
        release_bus();
    endtask

    task automatic t_both_strobes();
        int len;
        run_access("R10", 1'b0, 1'b1, mk_addr(1, 2), 16'h1234, len);
        release_bus();
        run_access("R10", 1'b1, 1'b1, mk_addr(1, 2), 16'hFFFF, len);
        check("R10 rd+wr acts as read", 32'(rdata), 32'h1234);
        release_bus();
        run_access("R10", 1'b1, 1'b0, mk_addr(0, 2), '0, len);
        check("R10 wdata not stored", 32'(rdata), 32'h1234);
        release_bus();
    endtask

    task automatic t_held_select();
        int len;
        run_access("R8", 1'b0, 1'b1, mk_addr(0, 1), 16'h0BEE, len);
        check("R8 first access length", 32'(len), 32'(stall_len(0)));
        check("R8 select ignored in completion cycle", 32'(waitreq), 32'd0);
        @(negedge clk);
        #1;
        check("R8 held select starts new access", 32'(waitreq), 32'd1);
        len = 0;
        while (waitreq === 1'b1 && len < 200) begin
            len++;
            @(negedge clk);
            #1;
        end
        check("R3 second access length", 32'(len), 32'(stall_len(0)));
        release_bus();
    endtask

    task automatic t_abort();
        int len;
        @(negedge clk);
        sel_n = 1'b0; rd = 1'b1; wr = 1'b0; addr = mk_addr(3, 0);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        release_bus();
        @(negedge clk);
        #1;
        check("R11 waitreq low after mid-access reset", 32'(waitreq), 32'd0);
        rst = 1'b0;
        run_access("R11", 1'b1, 1'b0, mk_addr(2, 0), '0, len);
        check("R11 next access normal length", 32'(len), 32'(stall_len(2)));
        check("R1 store cleared by reset", 32'(rdata), 32'd0);
        release_bus();
    endtask

    initial begin
        t_reset();
        t_regions();
        t_cross_region();
        t_deselected();
        t_both_strobes();
        t_held_select();
        t_abort();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule